// File: doc/BRIEF.md
# I/O device select decoder

This block sits beside a small processor core and turns an I/O instruction opcode into device selects. An opcode is captured into a register on a clock edge when a load strobe is high. Combinational decode then produces one active-low select strobe for one of eight input devices or for one of eight output devices. Any other opcode selects nothing. The strobes are static for as long as the captured opcode is held. The actual transfer happens only inside the active-low IN or OUT timing pulses that the core supplies.

On the input side, each of eight 8-bit input ports drives a shared read bus only while its control is low. That control is the OR of its select strobe and the IN pulse. A port that is not driving is treated as high-impedance: its bit in the driver-enable vector is clear, and the bus reads zero when nothing drives it. Port 0 is a sense port that returns eight external flag bits; ports 1 to 7 come from device inputs. On the output side, each of eight output latches has an enable formed as the NOR of its select strobe and the OUT pulse. A latch is transparent to the processor's write data while its enable is high and keeps that value once the enable drops.

The control pins (load, pulses, strobes) are plain level signals with no handshake. The core owns all timing.

Top module: `io_select_decoder`

## Requirements
- R1: While reset is asserted, every input and output select strobe is high, no driver enable is set, the bus reads zero and every output latch holds zero.
- R2: A captured opcode with bits [7:6]=01, bits [5:4]=00 and bit 0=1 pulls input strobe p low, with p = bits [3:1] (octal 111 gives port 4, octal 113 gives port 5).
- R3: A captured opcode with bits [7:6]=01, bits [5:4]=01 and bit 0=1 pulls output strobe p low, with p = bits [3:1] (octal 125 gives port 2, octal 131 gives port 4, octal 133 gives port 5).
- R4: Every other opcode leaves all sixteen strobes high, and at no time is more than one strobe low.
- R5: The control of input port p is the OR of its strobe and the IN pulse. Port p sets driver-enable bit p and places its data on the bus only while that control is low.
- R6: At most one of the eight port drivers and the processor write driver is enabled at a time. The processor drives the bus (with its write data) only while OUT is low and IN is high. With no driver enabled, the bus reads zero.
- R7: Input port 0 returns the eight external flag bits, and input port p (1 to 7) returns device input byte p-1.
- R8: The enable of output latch p is the NOR of its strobe and the OUT pulse. While it is high, the latch follows the write data.
- R9: After its enable falls, an output latch keeps its value whatever the write data does. Latches whose enable stays low never change.
- R10: The opcode register changes only on a clock edge with the load strobe high. Without load, new opcode inputs change no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the opcode register |
| rst_n | input | 1 | Active-low reset, clears opcode register and output latches |
| op_load | input | 1 | Capture op_in on the next rising clock edge |
| op_in | input | 8 | I/O instruction opcode |
| in_pulse_n | input | 1 | Active-low IN timing pulse |
| out_pulse_n | input | 1 | Active-low OUT timing pulse |
| sense_flags | input | DW | External flag bits read as input port 0 |
| dev_in | input | 7*DW | Data of input ports 1 to 7, port p at byte p-1 |
| cpu_wdata | input | DW | Processor write data placed on the bus during OUT |
| in_sel_n | output | 8 | Active-low input select strobes |
| out_sel_n | output | 8 | Active-low output select strobes |
| in_ctl_n | output | 8 | Active-low input port controls |
| out_en | output | 8 | Output latch enables, high = transparent |
| bus_drv | output | 8 | Input port driver enables |
| bus_data | output | DW | Resolved shared bus value |
| out_q | output | 8*DW | Output latch contents, port p at byte p |

## Verification
The bench builds the block with its default data width of 8 bits. That width matches the opcode and puts every one of the eight input and eight output ports within reach. Each of the eight input ports and each of the eight output ports is selected and pulsed in turn. The exact opcodes from the requirements are used alongside opcodes that differ from a valid code in a single field. Crossed cases are also covered: an OUT pulse under an input opcode, an IN pulse under an output opcode, and both pulses together. These show that the nine-driver bus never has two drivers and that the latches hold.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;
  localparam int OPW    = 8;
  localparam int PSEL_W = 3;
  localparam int NPORT  = 1 << PSEL_W;

  typedef enum logic [1:0] {IO_NONE = 2'd0, IO_RD = 2'd1, IO_WR = 2'd2} io_kind_e;

  function automatic io_kind_e io_classify(input logic [OPW-1:0] op);
    io_kind_e k;
    k = IO_NONE;
    if (op[7:6] == 2'b01 && op[0]) begin
      case (op[5:4])
        2'b00:   k = IO_RD;
        2'b01:   k = IO_WR;
        default: k = IO_NONE;
      endcase
    end
    return k;
  endfunction
endpackage

// File: rtl/io_op_capture.sv
module io_op_capture
  import io_dec_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [OPW-1:0] op_in,
  output logic [OPW-1:0] op_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    op_q <= '0;
    else if (load) op_q <= op_in;
  end
endmodule

// File: rtl/io_sel_decode.sv
module io_sel_decode
  import io_dec_pkg::*;
(
  input  logic [OPW-1:0]   op,
  output logic [NPORT-1:0] in_sel_n,
  output logic [NPORT-1:0] out_sel_n
);
  io_kind_e            kind;
  logic [PSEL_W-1:0]   pnum;

  assign kind = io_classify(op);
  assign pnum = op[PSEL_W:1];

  for (genvar i = 0; i < NPORT; i++) begin : g_sel
    assign in_sel_n[i]  = !(kind == IO_RD && pnum == PSEL_W'(i));
    assign out_sel_n[i] = !(kind == IO_WR && pnum == PSEL_W'(i));
  end
endmodule

// File: rtl/io_in_ports.sv
module io_in_ports
  import io_dec_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [NPORT-1:0]    sel_n,
  input  logic                in_pulse_n,
  input  logic [NPORT*DW-1:0] port_data,
  output logic [NPORT-1:0]    ctl_n,
  output logic [NPORT-1:0]    drv,
  output logic [DW-1:0]       rd_data
);
  for (genvar i = 0; i < NPORT; i++) begin : g_port
    assign ctl_n[i] = sel_n[i] | in_pulse_n;
    assign drv[i]   = !ctl_n[i];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NPORT; i++)
      rd_data = rd_data | (port_data[i*DW +: DW] & {DW{drv[i]}});
  end
endmodule

// File: rtl/io_out_latches.sv
module io_out_latches
  import io_dec_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                rst_n,
  input  logic [NPORT-1:0]    sel_n,
  input  logic                out_pulse_n,
  input  logic [DW-1:0]       bus,
  output logic [NPORT-1:0]    en,
  output logic [NPORT*DW-1:0] q
);
  for (genvar i = 0; i < NPORT; i++) begin : g_lat
    logic [DW-1:0] hold;
    assign en[i] = !(sel_n[i] | out_pulse_n);
    always_latch begin
      if (!rst_n)     hold <= '0;
      else if (en[i]) hold <= bus;
    end
    assign q[i*DW +: DW] = hold;
  end
endmodule

// File: rtl/io_select_decoder.sv
module io_select_decoder
  import io_dec_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    op_load,
  input  logic [7:0]              op_in,
  input  logic                    in_pulse_n,
  input  logic                    out_pulse_n,
  input  logic [DW-1:0]           sense_flags,
  input  logic [(NPORT-1)*DW-1:0] dev_in,
  input  logic [DW-1:0]           cpu_wdata,
  output logic [NPORT-1:0]        in_sel_n,
  output logic [NPORT-1:0]        out_sel_n,
  output logic [NPORT-1:0]        in_ctl_n,
  output logic [NPORT-1:0]        out_en,
  output logic [NPORT-1:0]        bus_drv,
  output logic [DW-1:0]           bus_data,
  output logic [NPORT*DW-1:0]     out_q
);
  logic [OPW-1:0]      op_q;
  logic [DW-1:0]       rd_data;
  logic                cpu_drv;
  logic [NPORT*DW-1:0] port_data;

  assign port_data = {dev_in, sense_flags};

  io_op_capture u_cap (
    .clk(clk), .rst_n(rst_n), .load(op_load), .op_in(op_in), .op_q(op_q)
  );

  io_sel_decode u_dec (
    .op(op_q), .in_sel_n(in_sel_n), .out_sel_n(out_sel_n)
  );

  io_in_ports #(.DW(DW)) u_inp (
    .sel_n(in_sel_n), .in_pulse_n(in_pulse_n), .port_data(port_data),
    .ctl_n(in_ctl_n), .drv(bus_drv), .rd_data(rd_data)
  );

  assign cpu_drv  = !out_pulse_n && in_pulse_n;
  assign bus_data = (|bus_drv) ? rd_data : (cpu_drv ? cpu_wdata : '0);

  io_out_latches #(.DW(DW)) u_outl (
    .rst_n(rst_n), .sel_n(out_sel_n), .out_pulse_n(out_pulse_n),
    .bus(bus_data), .en(out_en), .q(out_q)
  );
endmodule

// File: rtl/io_select_decoder_chk.sv
module io_select_decoder_chk
  import io_dec_pkg::*;
#(
  parameter int DW = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                op_load,
  input logic                in_pulse_n,
  input logic                out_pulse_n,
  input logic [NPORT-1:0]    in_sel_n,
  input logic [NPORT-1:0]    out_sel_n,
  input logic [NPORT-1:0]    out_en,
  input logic [NPORT-1:0]    bus_drv,
  input logic [NPORT*DW-1:0] out_q
);
  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~{in_sel_n, out_sel_n}));

  // R6
  one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_drv, (!out_pulse_n && in_pulse_n)}));

  // R5
  drive_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|bus_drv) |-> !in_pulse_n);

  // R8
  latch_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_en) |-> !out_pulse_n);

  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en == '0) |=> (out_en != '0) || $stable(out_q));

  // R10
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_load |=> $stable({in_sel_n, out_sel_n}));
endmodule

bind io_select_decoder io_select_decoder_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_load(op_load), .in_pulse_n(in_pulse_n),
  .out_pulse_n(out_pulse_n), .in_sel_n(in_sel_n), .out_sel_n(out_sel_n),
  .out_en(out_en), .bus_drv(bus_drv), .out_q(out_q)
);

// File: tb/sim_io_select_decoder.sv
`timescale 1ns/1ps
module sim_io_select_decoder;
  localparam int DW = 8;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          op_load = 0;
  logic [7:0]    op_in = 0;
  logic          in_pulse_n = 1;
  logic          out_pulse_n = 1;
  logic [7:0]    sense_flags = 8'h00;
  logic [55:0]   dev_in = 56'h77_66_55_44_33_22_11;
  logic [7:0]    cpu_wdata = 0;
  logic [7:0]    in_sel_n, out_sel_n, in_ctl_n, out_en, bus_drv, bus_data;
  logic [63:0]   out_q;

  int checks = 0;
  int errors = 0;

  int   m_op = 0;
  logic [7:0] m_q [8];

  always #2.5 clk = ~clk;

  io_select_decoder #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .op_load(op_load), .op_in(op_in),
    .in_pulse_n(in_pulse_n), .out_pulse_n(out_pulse_n),
    .sense_flags(sense_flags), .dev_in(dev_in), .cpu_wdata(cpu_wdata),
    .in_sel_n(in_sel_n), .out_sel_n(out_sel_n), .in_ctl_n(in_ctl_n),
    .out_en(out_en), .bus_drv(bus_drv), .bus_data(bus_data), .out_q(out_q)
  );

  function automatic int dec_port(int op, int kind);
    if ((op >> 6) == 1 && (op % 2) == 1 && ((op >> 4) % 4) == kind)
      return (op >> 1) % 8;
    return -1;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare();
    int ip, op;
    logic [7:0] e_isel, e_osel, e_ctl, e_en, e_drv, e_bus, pd;
    logic [63:0] e_q;
    ip = dec_port(m_op, 0);
    op = dec_port(m_op, 1);
    e_isel = 8'hFF; e_osel = 8'hFF; e_en = 0; e_drv = 0; e_bus = 0;
    if (ip >= 0) e_isel[ip] = 1'b0;
    if (op >= 0) e_osel[op] = 1'b0;
    e_ctl = in_pulse_n ? 8'hFF : e_isel;
    if (ip >= 0 && !in_pulse_n) begin
      e_drv[ip] = 1'b1;
      pd = (ip == 0) ? sense_flags : dev_in[(ip-1)*8 +: 8];
      e_bus = pd;
    end else if (!out_pulse_n && in_pulse_n) begin
      e_bus = cpu_wdata;
    end
    if (op >= 0 && !out_pulse_n) begin
      e_en[op] = 1'b1;
      m_q[op] = e_bus;
    end
    for (int i = 0; i < 8; i++) e_q[i*8 +: 8] = m_q[i];
    chk("R2/R3/R4/R10 in_sel_n", 64'(in_sel_n), 64'(e_isel));
    chk("R2/R3/R4/R10 out_sel_n", 64'(out_sel_n), 64'(e_osel));
    chk("R5 in_ctl_n", 64'(in_ctl_n), 64'(e_ctl));
    chk("R5/R6 bus_drv", 64'(bus_drv), 64'(e_drv));
    chk("R5/R6/R7 bus_data", 64'(bus_data), 64'(e_bus));
    chk("R8 out_en", 64'(out_en), 64'(e_en));
    chk("R8/R9 out_q", out_q, e_q);
  endtask

  // One clock: drive at the falling edge, capture at the rising edge,
  // compare just before the next falling edge.
  task automatic cyc(logic ld, logic [7:0] op, logic in_n, logic out_n, logic [7:0] wd);
    op_load = ld; op_in = op; in_pulse_n = in_n; out_pulse_n = out_n; cpu_wdata = wd;
    @(posedge clk);
    if (ld) m_op = int'(op);
    #1;
    compare();
    @(negedge clk);
  endtask

  task automatic sel(logic [7:0] op);
    cyc(1, op, 1, 1, cpu_wdata);
    cyc(0, op, 1, 1, cpu_wdata);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_q[i] = 8'h00;
    @(negedge clk); @(negedge clk);
    // R1: reset state
    chk("R1 in_sel_n", 64'(in_sel_n), 64'hFF);
    chk("R1 out_sel_n", 64'(out_sel_n), 64'hFF);
    chk("R1 bus_drv", 64'(bus_drv), 64'h0);
    chk("R1 bus_data", 64'(bus_data), 64'h0);
    chk("R1 out_q", out_q, 64'h0);
    rst_n = 1;
    @(negedge clk);

    // R2/R5: octal 111 -> input 4, 113 -> input 5
    sel(8'o111); cyc(0, 8'o111, 0, 1, 0); cyc(0, 8'o111, 1, 1, 0);
    sel(8'o113); cyc(0, 8'o113, 0, 1, 0); cyc(0, 8'o113, 1, 1, 0);
    // R7: sense port with two flag patterns
    sense_flags = 8'hA6;
    sel(8'o101); cyc(0, 8'o101, 0, 1, 0);
    sense_flags = 8'h59; cyc(0, 8'o101, 0, 1, 0); cyc(0, 8'o101, 1, 1, 0);
    // every input port
    for (int p = 0; p < 8; p++) begin
      sel(8'(8'o101 + 2*p)); cyc(0, 8'(8'o101 + 2*p), 0, 1, 0); cyc(0, 8'(8'o101 + 2*p), 1, 1, 0);
    end

    // R3/R8/R9: octal 125 -> output 2, then hold while write data changes
    sel(8'o125);
    cyc(0, 8'o125, 1, 0, 8'h3C); cyc(0, 8'o125, 1, 0, 8'hC3);
    cyc(0, 8'o125, 1, 1, 8'hC3); cyc(0, 8'o125, 1, 1, 8'h11);
    sel(8'o131); cyc(0, 8'o131, 1, 0, 8'h44); cyc(0, 8'o131, 1, 1, 8'h44); cyc(0, 8'o131, 1, 1, 8'hEE);
    sel(8'o133); cyc(0, 8'o133, 1, 0, 8'h55); cyc(0, 8'o133, 1, 1, 8'h55); cyc(0, 8'o133, 1, 1, 8'h00);
    for (int p = 0; p < 8; p++) begin
      sel(8'(8'o121 + 2*p));
      cyc(0, 8'(8'o121 + 2*p), 1, 0, 8'(8'h90 + p));
      cyc(0, 8'(8'o121 + 2*p), 1, 1, 8'(8'h90 + p));
      cyc(0, 8'(8'o121 + 2*p), 1, 1, 8'hFF);
    end

    // R10: new opcode without load changes nothing
    cyc(0, 8'o111, 1, 1, 0); cyc(0, 8'o131, 1, 0, 8'h77); cyc(0, 8'o131, 1, 1, 8'h77);

    // R4: opcodes off by one field select nothing; pulses have no effect
    sel(8'o301); cyc(0, 8'o301, 0, 1, 0); cyc(0, 8'o301, 1, 0, 8'hAB); cyc(0, 8'o301, 1, 1, 8'hAB);
    sel(8'o145); cyc(0, 8'o145, 0, 1, 0); cyc(0, 8'o145, 1, 0, 8'hCD); cyc(0, 8'o145, 1, 1, 8'hCD);
    sel(8'o110); cyc(0, 8'o110, 0, 1, 0); cyc(0, 8'o110, 1, 0, 8'hEF); cyc(0, 8'o110, 1, 1, 8'hEF);

    // R6: crossed pulses
    sel(8'o111); cyc(0, 8'o111, 1, 0, 8'h5A); cyc(0, 8'o111, 0, 0, 8'h5A); cyc(0, 8'o111, 1, 1, 8'h5A);
    sel(8'o125); cyc(0, 8'o125, 0, 1, 8'h12); cyc(0, 8'o125, 1, 1, 8'h12);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule